// File: doc/BRIEF.md
# Serial Divider-Ratio Loader

This block accepts a configuration word on three slow serial pins (a data bit, a serial clock and a load enable) and places it into one of two holding registers for a frequency synthesizer. The serial pins are resynchronized into the fast system clock domain. Each rising edge of the serial clock shifts one data bit into a common shift path, most significant bit first. The bit that arrives last is a control flag, and it selects the destination.

A rising edge on load enable triggers the transfer. A control flag of 1 sends the word to the reference register, which holds a prescaler-select bit and a 14-bit reference ratio. A control flag of 0 sends it to the main register, which holds an 11-bit program count and a 7-bit swallow count. A one-cycle strobe marks the register that was written, and the other register keeps its value. A bit counter ensures that a transfer happens only when enough bits have arrived for the chosen frame. The counter restarts after every load.

Top module: `serial_ratio_loader`

## Requirements
- R1: After reset, every latched field reads zero and both update strobes are low. Load enable is taken as high during reset (pull-up idle), so holding it high out of reset causes no transfer.
- R2: A data bit is shifted in on each rising edge of the serial clock. Words are sent most significant bit first, and the control flag is the last bit sent.
- R3: On a load with control flag 1, the last 16 bits form the reference word, in send order: prescaler select, then reference ratio bit 13 down to bit 0, then the flag.
- R4: On a load with control flag 0, the last 19 bits form the main word, in send order: program count bit 10 down to bit 0, then swallow count bit 6 down to bit 0, then the flag.
- R5: Each accepted load raises exactly one update strobe (`ref_update` or `main_update`) for exactly one system clock cycle. The two strobes are never high together.
- R6: A load into one register leaves every field of the other register unchanged.
- R7: Bits sent before the final frame-length bits are discarded.
- R8: A load is ignored if fewer bits were shifted since the previous load than the selected frame needs (16 for reference, 19 for main). An ignored load raises no strobe and changes no field.
- R9: A transfer happens only on a low-to-high change of load enable. A second load pulse with no new bits in between is ignored.
- R10: Data changes while the serial clock is high or falling have no effect. The bit taken is the one present at the rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk | input | 1 | Serial shift clock (asynchronous, slow) |
| ser_data | input | 1 | Serial data bit |
| ser_load | input | 1 | Load enable (idle high) |
| ref_presc_sel | output | 1 | Latched prescaler-select bit |
| ref_ratio | output | 14 | Latched reference divide ratio |
| main_count | output | 11 | Latched program count |
| swallow_count | output | 7 | Latched swallow count |
| ref_update | output | 1 | One-cycle strobe: reference register written |
| main_update | output | 1 | One-cycle strobe: main register written |

## Verification
Several kinds of word are sent to each register. Words with mixed bits expose a swapped or shifted field boundary. All-ones and minimum-value words expose a truncated field or a mis-sliced position. Streams with extra leading bits show whether only the tail of the shift path is used. Streams that are too short, and repeated load pulses with no new bits, show whether the bit counter gates the transfer. A word whose data bits toggle while the serial clock is high shows that only the rising edge samples data. After every load, the scoreboard compares all four fields, so a write that leaks into the other register is caught.

// File: rtl/ratio_cfg_pkg.sv
package ratio_cfg_pkg;

   typedef enum logic [1:0] {
      DEST_NONE = 2'd0,
      DEST_REF  = 2'd1,
      DEST_MAIN = 2'd2
   } dest_e;

   function automatic int max_int(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/level_sync.sv
module level_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic level
);
   logic [STAGES-1:0] chain;

   generate
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[0] <= RST_VAL;
               else        chain[0] <= din;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[i] <= RST_VAL;
               else        chain[i] <= chain[i-1];
            end
         end
      end
   endgenerate

   assign level = chain[STAGES-1];
endmodule

// File: rtl/rise_detect.sv
module rise_detect #(
   parameter logic RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic level,
   output logic rise
);
   logic prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev <= RST_VAL;
      else        prev <= level;
   end

   assign rise = level & ~prev;
endmodule

// File: rtl/frame_shifter.sv
module frame_shifter #(
   parameter int SHIFT_W = 19,
   parameter int CB      = 5
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               shift_en,
   input  logic               bit_in,
   input  logic               clear,
   output logic [SHIFT_W-1:0] shreg,
   output logic [CB-1:0]      bit_count
);
   localparam logic [CB-1:0] SAT = CB'(SHIFT_W);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg     <= '0;
         bit_count <= '0;
      end else if (clear) begin
         bit_count <= '0;
      end else if (shift_en) begin
         shreg <= {shreg[SHIFT_W-2:0], bit_in};
         if (bit_count != SAT) bit_count <= bit_count + 1'b1;
      end
   end
endmodule

// File: rtl/frame_router.sv
module frame_router
   import ratio_cfg_pkg::*;
#(
   parameter int REF_W   = 14,
   parameter int CNT_W   = 11,
   parameter int SWL_W   = 7,
   parameter int SHIFT_W = 19,
   parameter int CB      = 5
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load,
   input  logic [SHIFT_W-1:0] shreg,
   input  logic [CB-1:0]      bit_count,
   output logic               ref_presc_sel,
   output logic [REF_W-1:0]   ref_ratio,
   output logic [CNT_W-1:0]   main_count,
   output logic [SWL_W-1:0]   swallow_count,
   output logic               ref_update,
   output logic               main_update
);
   localparam int REF_FRAME  = REF_W + 2;
   localparam int MAIN_FRAME = CNT_W + SWL_W + 1;
   localparam logic [CB-1:0] REF_NEED  = CB'(REF_FRAME);
   localparam logic [CB-1:0] MAIN_NEED = CB'(MAIN_FRAME);

   dest_e dest;

   always_comb begin
      dest = DEST_NONE;
      if (load) begin
         if (shreg[0]) begin
            if (bit_count >= REF_NEED)  dest = DEST_REF;
         end else begin
            if (bit_count >= MAIN_NEED) dest = DEST_MAIN;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ref_presc_sel <= 1'b0;
         ref_ratio     <= '0;
         main_count    <= '0;
         swallow_count <= '0;
         ref_update    <= 1'b0;
         main_update   <= 1'b0;
      end else begin
         ref_update  <= 1'b0;
         main_update <= 1'b0;
         case (dest)
            DEST_REF: begin
               ref_presc_sel <= shreg[REF_W+1];
               ref_ratio     <= shreg[REF_W:1];
               ref_update    <= 1'b1;
            end
            DEST_MAIN: begin
               main_count    <= shreg[CNT_W+SWL_W:SWL_W+1];
               swallow_count <= shreg[SWL_W:1];
               main_update   <= 1'b1;
            end
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/serial_ratio_loader.sv
module serial_ratio_loader #(
   parameter int REF_W       = 14,
   parameter int CNT_W       = 11,
   parameter int SWL_W       = 7,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ser_clk,
   input  logic             ser_data,
   input  logic             ser_load,
   output logic             ref_presc_sel,
   output logic [REF_W-1:0] ref_ratio,
   output logic [CNT_W-1:0] main_count,
   output logic [SWL_W-1:0] swallow_count,
   output logic             ref_update,
   output logic             main_update
);
   localparam int REF_FRAME  = REF_W + 2;
   localparam int MAIN_FRAME = CNT_W + SWL_W + 1;
   localparam int SHIFT_W    = ratio_cfg_pkg::max_int(REF_FRAME, MAIN_FRAME);
   localparam int CB         = $clog2(SHIFT_W + 1);

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (REF_W < 1 || CNT_W < 1 || SWL_W < 1) begin : g_bad_width
         $error("field widths must be positive");
      end
      if (MAIN_FRAME < REF_FRAME) begin : g_bad_order
         $error("main frame must not be shorter than reference frame");
      end
   endgenerate

   logic clk_lvl, data_lvl, load_lvl;
   logic clk_rise, load_rise;
   logic [SHIFT_W-1:0] shreg;
   logic [CB-1:0]      bit_count;

   level_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) i_sync_clk (
      .clk(clk), .rst_n(rst_n), .din(ser_clk), .level(clk_lvl));
   level_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) i_sync_data (
      .clk(clk), .rst_n(rst_n), .din(ser_data), .level(data_lvl));
   level_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) i_sync_load (
      .clk(clk), .rst_n(rst_n), .din(ser_load), .level(load_lvl));

   rise_detect #(.RST_VAL(1'b0)) i_rise_clk (
      .clk(clk), .rst_n(rst_n), .level(clk_lvl), .rise(clk_rise));
   rise_detect #(.RST_VAL(1'b1)) i_rise_load (
      .clk(clk), .rst_n(rst_n), .level(load_lvl), .rise(load_rise));

   frame_shifter #(.SHIFT_W(SHIFT_W), .CB(CB)) i_shifter (
      .clk(clk), .rst_n(rst_n), .shift_en(clk_rise), .bit_in(data_lvl),
      .clear(load_rise), .shreg(shreg), .bit_count(bit_count));

   frame_router #(.REF_W(REF_W), .CNT_W(CNT_W), .SWL_W(SWL_W),
                  .SHIFT_W(SHIFT_W), .CB(CB)) i_router (
      .clk(clk), .rst_n(rst_n), .load(load_rise), .shreg(shreg),
      .bit_count(bit_count), .ref_presc_sel(ref_presc_sel),
      .ref_ratio(ref_ratio), .main_count(main_count),
      .swallow_count(swallow_count), .ref_update(ref_update),
      .main_update(main_update));
endmodule

// File: rtl/ratio_loader_checker.sv
module ratio_loader_checker #(
   parameter int REF_W = 14,
   parameter int CNT_W = 11,
   parameter int SWL_W = 7
) (
   input logic             clk,
   input logic             rst_n,
   input logic             ref_presc_sel,
   input logic [REF_W-1:0] ref_ratio,
   input logic [CNT_W-1:0] main_count,
   input logic [SWL_W-1:0] swallow_count,
   input logic             ref_update,
   input logic             main_update
);
   assert_strobe_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({ref_update, main_update}));

   assert_ref_pulse_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ref_update |=> !ref_update);

   assert_main_pulse_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
      main_update |=> !main_update);

   assert_ref_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !ref_update |-> $stable({ref_presc_sel, ref_ratio}));

   assert_main_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !main_update |-> $stable({main_count, swallow_count}));
endmodule

bind serial_ratio_loader ratio_loader_checker #(
   .REF_W(REF_W), .CNT_W(CNT_W), .SWL_W(SWL_W)
) i_ratio_loader_checker (
   .clk(clk), .rst_n(rst_n), .ref_presc_sel(ref_presc_sel),
   .ref_ratio(ref_ratio), .main_count(main_count),
   .swallow_count(swallow_count), .ref_update(ref_update),
   .main_update(main_update));

// File: tb/test_serial_ratio_loader.sv
`timescale 1ns/1ps
module test_serial_ratio_loader;
   localparam int HALF = 10;

   typedef struct packed {
      logic        is_ref;
      logic        presc;
      logic [13:0] ratio;
      logic [10:0] cnt;
      logic [6:0]  swl;
   } item_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ser_clk = 1'b0;
   logic ser_data = 1'b0;
   logic ser_load = 1'b1;
   logic        ref_presc_sel;
   logic [13:0] ref_ratio;
   logic [10:0] main_count;
   logic [6:0]  swallow_count;
   logic        ref_update;
   logic        main_update;

   int n_checks = 0;
   int n_errors = 0;
   bit finished = 0;

   item_t exp_q[$];
   string tag_q[$];

   logic        m_presc = 1'b0;
   logic [13:0] m_ratio = '0;
   logic [10:0] m_cnt = '0;
   logic [6:0]  m_swl = '0;

   always #10 clk = ~clk;

   serial_ratio_loader i_serial_ratio_loader (
      .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data),
      .ser_load(ser_load), .ref_presc_sel(ref_presc_sel),
      .ref_ratio(ref_ratio), .main_count(main_count),
      .swallow_count(swallow_count), .ref_update(ref_update),
      .main_update(main_update));

   task automatic wait_cyc(input int n);
      repeat (n) @(posedge clk);
   endtask

   task automatic send_bits(input logic [31:0] bits, input int n, input bit glitch);
      for (int i = n - 1; i >= 0; i--) begin
         ser_data = bits[i];
         wait_cyc(HALF);
         ser_clk = 1'b1;
         wait_cyc(HALF / 2);
         if (glitch) ser_data = ~bits[i];
         wait_cyc(HALF - HALF / 2);
         ser_clk = 1'b0;
         wait_cyc(HALF / 2);
         if (glitch) ser_data = bits[i];
      end
   endtask

   task automatic pulse_load();
      wait_cyc(HALF);
      ser_load = 1'b1;
      wait_cyc(2 * HALF);
      ser_load = 1'b0;
      wait_cyc(2 * HALF);
   endtask

   task automatic expect_ref(input logic p, input logic [13:0] r, input string tag);
      m_presc = p; m_ratio = r;
      exp_q.push_back({1'b1, m_presc, m_ratio, m_cnt, m_swl});
      tag_q.push_back(tag);
   endtask

   task automatic expect_main(input logic [10:0] c, input logic [6:0] s, input string tag);
      m_cnt = c; m_swl = s;
      exp_q.push_back({1'b0, m_presc, m_ratio, m_cnt, m_swl});
      tag_q.push_back(tag);
   endtask

   task automatic load_ref(input logic p, input logic [13:0] r, input string tag);
      send_bits({16'd0, p, r, 1'b1}, 16, 1'b0);
      expect_ref(p, r, tag);
      pulse_load();
   endtask

   task automatic load_main(input logic [10:0] c, input logic [6:0] s, input string tag);
      send_bits({13'd0, c, s, 1'b0}, 19, 1'b0);
      expect_main(c, s, tag);
      pulse_load();
   endtask

   task automatic check_hold(input string tag);
      @(negedge clk);
      n_checks++;
      if ({ref_presc_sel, ref_ratio, main_count, swallow_count} !== {m_presc, m_ratio, m_cnt, m_swl}) begin
         n_errors++;
         $display("FAIL %s: actual %h %h %h %h expected %h %h %h %h", tag,
                  ref_presc_sel, ref_ratio, main_count, swallow_count,
                  m_presc, m_ratio, m_cnt, m_swl);
      end
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         if (ref_update && main_update) begin
            n_checks++; n_errors++;
            $display("FAIL R5 both strobes: actual 11 expected one-hot");
         end else if (ref_update || main_update) begin
            n_checks++;
            if (exp_q.size() == 0) begin
               n_errors++;
               $display("FAIL R8/R9 unexpected strobe: actual ref=%b main=%b expected none",
                        ref_update, main_update);
            end else begin
               item_t e;
               item_t g;
               string t;
               e = exp_q.pop_front();
               t = tag_q.pop_front();
               g = {ref_update, ref_presc_sel, ref_ratio, main_count, swallow_count};
               if (g !== e) begin
                  n_errors++;
                  $display("FAIL %s: actual %h expected %h", t, g, e);
               end
            end
         end
      end
   end

   initial begin
      wait_cyc(200000);
      if (!finished) begin
         finished = 1;
         n_checks++; n_errors++;
         $display("FAIL R5 watchdog: actual running expected done");
         $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
         $finish;
      end
   end

   initial begin
      wait_cyc(5);
      rst_n = 1'b1;
      wait_cyc(10);
      // R1: reset state, load enable held high out of reset gives no transfer
      check_hold("R1 reset fields");
      @(negedge clk);
      n_checks++;
      if (ref_update || main_update) begin
         n_errors++;
         $display("FAIL R1 strobes: actual %b%b expected 00", ref_update, main_update);
      end
      ser_load = 1'b0;
      wait_cyc(2 * HALF);

      // R2 R3: reference word, mixed bits
      load_ref(1'b1, 14'h1234, "R3 ref mixed");
      // R4 R6: main word, ref kept
      load_main(11'h5A3, 7'h2B, "R4 main mixed");
      // R3 boundaries
      load_ref(1'b0, 14'h3FFF, "R3 ref all ones");
      load_ref(1'b1, 14'd8, "R3 ref minimum");
      // R4 boundaries, R6 other register intact
      load_main(11'd16, 7'd0, "R4 main minimum");
      load_main(11'h7FF, 7'h7F, "R4 main all ones");
      check_hold("R6 after main loads");

      // R7: extra leading bits discarded
      send_bits(32'h5, 3, 1'b0);
      send_bits({16'd0, 1'b0, 14'h0A5C, 1'b1}, 16, 1'b0);
      expect_ref(1'b0, 14'h0A5C, "R7 ref extra lead");
      pulse_load();
      send_bits(32'h1F, 5, 1'b0);
      send_bits({13'd0, 11'h2C6, 7'h55, 1'b0}, 19, 1'b0);
      expect_main(11'h2C6, 7'h55, "R7 main extra lead");
      pulse_load();

      // R8: short frames ignored
      send_bits(32'hFFF, 12, 1'b0);
      pulse_load();
      check_hold("R8 short ref frame");
      send_bits({15'd0, 17'h1AAAA}, 17, 1'b0);
      pulse_load();
      check_hold("R8 short main frame");

      // R9: repeated pulse without new bits
      load_ref(1'b1, 14'h2222, "R9 ref before repeat");
      pulse_load();
      check_hold("R9 repeat pulse ignored");

      // R10: data toggles while serial clock high
      send_bits({16'd0, 1'b1, 14'h1DB6, 1'b1}, 16, 1'b1);
      expect_ref(1'b1, 14'h1DB6, "R10 rising edge sample");
      pulse_load();
      send_bits({13'd0, 11'h4E1, 7'h3A, 1'b0}, 19, 1'b1);
      expect_main(11'h4E1, 7'h3A, "R10 main rising edge");
      pulse_load();
      check_hold("R6 final state");

      wait_cyc(20);
      n_checks++;
      if (exp_q.size() != 0) begin
         n_errors++;
         $display("FAIL R5 missing strobes: actual %0d pending expected 0", exp_q.size());
      end
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
      $finish;
   end
endmodule